// File: doc/BRIEF.md
# SD Host Transfer Status Tracker

This block follows the data side of an SD host controller and reports its live transfer state as three read-only flags: a write-buffer-open flag, a receive-busy flag and a transmit-busy flag. It takes single-cycle event strobes from the command and data engines. These cover the end bit of a read or write command, a block handed to the system, a block CRC status returned by the card, buffer space freed and a buffer filled. It also takes register-write strobes for stop-at-gap and resume requests, the programmed block count and a multi-block selector.

Each falling or rising edge of a flag produces a one-cycle interrupt pulse. The pulse is raised in the same cycle as the flag change. A receive-busy fall always raises transfer-done. A transmit-busy fall raises transfer-done when the block count has been used up, and raises gap-event when it comes from a stop request. A rising write-buffer-open flag raises write-ready. An internal block counter tracks how many blocks remain, so a transfer that stops at a block gap can be resumed where it stopped.

Top module: `sd_xfer_status_tracker`

## Requirements
- R1: After reset, all three flags and all three interrupt pulses are 0.
- R2: A read command end strobe sets rx_busy_o one cycle later. A write command end strobe sets tx_busy_o one cycle later.
- R3: The blocks to move equal blk_count_i when multi_blk_i is 1 and blk_count_i is nonzero, and equal 1 otherwise. The number is latched at command end. The block-delivered strobe that moves the last block clears rx_busy_o, and xfer_done_irq_o pulses for one cycle in that same cycle.
- R4: The write-side CRC status strobe for the last block clears tx_busy_o and pulses xfer_done_irq_o, not gap_evt_irq_o.
- R5: A stop-at-gap request written while a read is running clears rx_busy_o at the next block delivered and pulses xfer_done_irq_o.
- R6: A stop-at-gap request written while a write is running clears tx_busy_o at the next CRC status that is not for the last block. It pulses gap_evt_irq_o and does not pulse xfer_done_irq_o.
- R7: A resume request while stopped at a gap sets the busy flag of the stopped direction again and cancels the pending stop. The blocks still remaining then complete the transfer normally.
- R8: A resume request with no pending stop, or with no blocks remaining, changes no flag.
- R9: wbuf_open_o can be 1 only while a write is running and dma_mode_i is 0. It rises on buf_space_i, falls on buf_full_i, and each rise pulses wr_ready_irq_o for one cycle.
- R10: When a set event and a clear event hit the same flag in one cycle, the flag ends up 1 and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_cmd_end_i | input | 1 | End bit of a read command seen |
| wr_cmd_end_i | input | 1 | End bit of a write command seen |
| rd_blk_done_i | input | 1 | One read block delivered to the system |
| wr_crc_seen_i | input | 1 | CRC status for one written block received |
| buf_space_i | input | 1 | Room for the start of a block is available |
| buf_full_i | input | 1 | All data of the current block written to the buffer |
| dma_mode_i | input | 1 | Transfer uses DMA (write-buffer-open suppressed) |
| resume_wr_i | input | 1 | Resume request written as 1 |
| stop_gap_wr_i | input | 1 | Stop-at-gap request written as 1 |
| blk_count_i | input | CNT_W | Programmed block count |
| multi_blk_i | input | 1 | Multi-block transfer selected |
| wbuf_open_o | output | 1 | Write buffer accepts data |
| rx_busy_o | output | 1 | Read transfer active |
| tx_busy_o | output | 1 | Write transfer active |
| wr_ready_irq_o | output | 1 | Write-ready interrupt pulse |
| xfer_done_irq_o | output | 1 | Transfer-done interrupt pulse |
| gap_evt_irq_o | output | 1 | Block-gap-event interrupt pulse |

## Verification
Every flag and every interrupt pulse comes from a register fed directly by the strobes. So the result of a strobe held through one clock edge is due right after that edge. The bench drives the inputs 1 ns after a rising edge, holds them through the next edge, clears them, and samples the outputs in the same off-edge window. One further step then confirms that each pulse lasted exactly one cycle. The sweeps cover both directions, both block modes and block counts 0 to 4. For each block event, the expected cycle of the flag fall is computed in the bench from the count rule.

// File: rtl/sd_xfer_pkg.sv
package sd_xfer_pkg;

  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} xfer_dir_e;

  // Blocks the counter starts from: a single-block or zero-count transfer moves one block.
  function automatic int unsigned blocks_to_move(int unsigned prog, logic multi);
    return (!multi || prog == 0) ? 1 : prog;
  endfunction

endpackage

// File: rtl/sd_blk_counter.sv
module sd_blk_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] prog_i,
  input  logic             multi_i,
  input  logic             step_i,
  output logic             last_o,
  output logic [CNT_W-1:0] left_o
);
  import sd_xfer_pkg::*;

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      left_q <= '0;
    else if (load_i)                 left_q <= CNT_W'(blocks_to_move(32'(prog_i), multi_i));
    else if (step_i && left_q != '0) left_q <= left_q - 1'b1;
  end

  assign last_o = step_i && (left_q == CNT_W'(1));
  assign left_o = left_q;

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> left_q != '0);

endmodule

// File: rtl/sd_status_flag.sv
module sd_status_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic nxt_o,
  output logic rise_o,
  output logic fall_o
);
  logic q;

  assign nxt_o  = set_i | (q & ~clr_i);
  assign rise_o = nxt_o & ~q;
  assign fall_o = ~nxt_o & q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt_o;
  end

  assign q_o = q;

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

endmodule

// File: rtl/sd_xfer_status_tracker.sv
module sd_xfer_status_tracker #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_cmd_end_i,
  input  logic             wr_cmd_end_i,
  input  logic             rd_blk_done_i,
  input  logic             wr_crc_seen_i,
  input  logic             buf_space_i,
  input  logic             buf_full_i,
  input  logic             dma_mode_i,
  input  logic             resume_wr_i,
  input  logic             stop_gap_wr_i,
  input  logic [CNT_W-1:0] blk_count_i,
  input  logic             multi_blk_i,
  output logic             wbuf_open_o,
  output logic             rx_busy_o,
  output logic             tx_busy_o,
  output logic             wr_ready_irq_o,
  output logic             xfer_done_irq_o,
  output logic             gap_evt_irq_o
);
  import sd_xfer_pkg::*;

  xfer_dir_e        dir_q;
  logic             stop_pend_q;
  logic             rx_q, tx_q, tx_nxt, rx_nxt_unused;
  logic             rx_rise, rx_fall, tx_rise, tx_fall;
  logic             rd_blk_evt, wr_blk_evt, blk_step, last_blk, cmd_end, resume_ok;
  logic             rx_set, rx_clr, tx_set, tx_clr;
  logic [CNT_W-1:0] blocks_left;
  logic             wbuf_q, wbuf_nxt;
  logic             irq_wr_ready_q, irq_done_q, irq_gap_q;

  // Named internal events
  assign rd_blk_evt = rd_blk_done_i & rx_q;
  assign wr_blk_evt = wr_crc_seen_i & tx_q;
  assign blk_step   = rd_blk_evt | wr_blk_evt;
  assign cmd_end    = rd_cmd_end_i | wr_cmd_end_i;
  assign resume_ok  = resume_wr_i & stop_pend_q & ~rx_q & ~tx_q & (blocks_left != '0);

  assign rx_set = rd_cmd_end_i | (resume_ok & (dir_q == DIR_RD));
  assign rx_clr = rd_blk_evt & (last_blk | stop_pend_q);
  assign tx_set = wr_cmd_end_i | (resume_ok & (dir_q == DIR_WR));
  assign tx_clr = wr_blk_evt & (last_blk | stop_pend_q);

  sd_blk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(cmd_end), .prog_i(blk_count_i),
    .multi_i(multi_blk_i), .step_i(blk_step), .last_o(last_blk), .left_o(blocks_left)
  );

  sd_status_flag u_rx (
    .clk(clk), .rst_n(rst_n), .set_i(rx_set), .clr_i(rx_clr),
    .q_o(rx_q), .nxt_o(rx_nxt_unused), .rise_o(rx_rise), .fall_o(rx_fall)
  );

  sd_status_flag u_tx (
    .clk(clk), .rst_n(rst_n), .set_i(tx_set), .clr_i(tx_clr),
    .q_o(tx_q), .nxt_o(tx_nxt), .rise_o(tx_rise), .fall_o(tx_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q       <= DIR_RD;
      stop_pend_q <= 1'b0;
    end else begin
      if (wr_cmd_end_i)      dir_q <= DIR_WR;
      else if (rd_cmd_end_i) dir_q <= DIR_RD;
      if (cmd_end || resume_ok) stop_pend_q <= 1'b0;
      else if (stop_gap_wr_i)   stop_pend_q <= 1'b1;
    end
  end

  assign wbuf_nxt = tx_nxt & ~dma_mode_i & (buf_space_i | (wbuf_q & ~buf_full_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbuf_q         <= 1'b0;
      irq_wr_ready_q <= 1'b0;
      irq_done_q     <= 1'b0;
      irq_gap_q      <= 1'b0;
    end else begin
      wbuf_q         <= wbuf_nxt;
      irq_wr_ready_q <= wbuf_nxt & ~wbuf_q;
      irq_done_q     <= rx_fall | (tx_fall & last_blk);
      irq_gap_q      <= tx_fall & ~last_blk;
    end
  end

  assign wbuf_open_o     = wbuf_q;
  assign rx_busy_o       = rx_q;
  assign tx_busy_o       = tx_q;
  assign wr_ready_irq_o  = irq_wr_ready_q;
  assign xfer_done_irq_o = irq_done_q;
  assign gap_evt_irq_o   = irq_gap_q;

  // R3
  rx_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_busy_o) |-> xfer_done_irq_o);
  // R6
  gap_from_tx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_evt_irq_o |-> $fell(tx_busy_o) && !xfer_done_irq_o);
  // R9
  wbuf_needs_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbuf_open_o |-> tx_busy_o);
  // R9
  wbuf_rise_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wbuf_open_o) |-> wr_ready_irq_o);
  // R2
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_end_i |=> rx_busy_o);

endmodule

// File: tb/tb_sd_xfer_status_tracker.sv
module tb_sd_xfer_status_tracker;
  localparam int CNT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_cmd_end_i = 0, wr_cmd_end_i = 0, rd_blk_done_i = 0, wr_crc_seen_i = 0;
  logic buf_space_i = 0, buf_full_i = 0, dma_mode_i = 0, resume_wr_i = 0, stop_gap_wr_i = 0;
  logic [CNT_W-1:0] blk_count_i = '0;
  logic multi_blk_i = 0;
  logic wbuf_open_o, rx_busy_o, tx_busy_o, wr_ready_irq_o, xfer_done_irq_o, gap_evt_irq_o;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sd_xfer_status_tracker #(.CNT_W(CNT_W)) dut (.*);

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clear_strobes();
    rd_cmd_end_i = 0; wr_cmd_end_i = 0; rd_blk_done_i = 0; wr_crc_seen_i = 0;
    buf_space_i = 0; buf_full_i = 0; resume_wr_i = 0; stop_gap_wr_i = 0;
  endtask

  task automatic blk_evt(bit wr);
    if (wr) wr_crc_seen_i = 1; else rd_blk_done_i = 1;
    tick(); clear_strobes();
  endtask

  task automatic busy_chk(string req, bit wr, logic exp);
    chk(req, wr ? tx_busy_o : rx_busy_o, exp);
  endtask

  // R2 R3 R4: full transfer, fall due at the block computed from the count rule
  task automatic run_xfer(bit wr, bit multi, int cnt);
    int n;
    n = (multi && cnt != 0) ? cnt : 1;
    blk_count_i = CNT_W'(cnt); multi_blk_i = multi;
    if (wr) wr_cmd_end_i = 1; else rd_cmd_end_i = 1;
    tick(); clear_strobes();
    busy_chk("R2 busy after cmd end", wr, 1'b1);
    for (int i = 1; i <= n; i++) begin
      blk_evt(wr);
      busy_chk(wr ? "R4 tx busy per block" : "R3 rx busy per block", wr, i < n);
      chk(wr ? "R4 done pulse" : "R3 done pulse", xfer_done_irq_o, i == n);
      chk("R4 no gap pulse on full count", gap_evt_irq_o, 1'b0);
    end
    tick();
    chk("R3 done pulse lasts one cycle", xfer_done_irq_o, 1'b0);
  endtask

  // R5 R6 R7: stop after k blocks of four, resume, finish
  task automatic stop_resume(bit wr, int k);
    blk_count_i = 8'd4; multi_blk_i = 1;
    if (wr) wr_cmd_end_i = 1; else rd_cmd_end_i = 1;
    tick(); clear_strobes();
    resume_wr_i = 1; tick(); clear_strobes();
    busy_chk("R8 resume while running ignored", wr, 1'b1);
    for (int i = 1; i < k; i++) blk_evt(wr);
    busy_chk("R6 still busy before stop", wr, 1'b1);
    stop_gap_wr_i = 1; tick(); clear_strobes();
    busy_chk("R6 busy until next block", wr, 1'b1);
    blk_evt(wr);
    busy_chk(wr ? "R6 tx cleared at gap" : "R5 rx cleared at gap", wr, 1'b0);
    chk(wr ? "R6 gap pulse" : "R5 gap pulse absent on read", gap_evt_irq_o, wr);
    chk(wr ? "R6 no done pulse" : "R5 done pulse", xfer_done_irq_o, !wr);
    tick();
    resume_wr_i = 1; tick(); clear_strobes();
    busy_chk("R7 resume restarts direction", wr, 1'b1);
    chk("R7 other direction idle", wr ? rx_busy_o : tx_busy_o, 1'b0);
    for (int i = k + 1; i <= 4; i++) begin
      blk_evt(wr);
      busy_chk("R7 remaining blocks", wr, i < 4);
      chk("R7 done pulse at final block", xfer_done_irq_o, i == 4);
    end
    resume_wr_i = 1; tick(); clear_strobes();
    busy_chk("R8 resume with nothing pending ignored", wr, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3;
    chk("R1 reset rx", rx_busy_o, 1'b0);
    chk("R1 reset tx", tx_busy_o, 1'b0);
    chk("R1 reset wbuf", wbuf_open_o, 1'b0);
    tick(); rst_n = 1; tick();
    chk("R1 idle done irq", xfer_done_irq_o, 1'b0);
    chk("R1 idle gap irq", gap_evt_irq_o, 1'b0);
    chk("R1 idle ready irq", wr_ready_irq_o, 1'b0);

    for (int wr = 0; wr < 2; wr++)
      for (int m = 0; m < 2; m++)
        for (int c = 0; c <= 4; c++)
          run_xfer(wr[0], m[0], c);

    for (int wr = 0; wr < 2; wr++)
      for (int k = 1; k <= 3; k++)
        stop_resume(wr[0], k);

    // R9 write-buffer-open behaviour
    blk_count_i = 8'd2; multi_blk_i = 1; dma_mode_i = 0;
    buf_space_i = 1; tick(); clear_strobes();
    chk("R9 no open while idle", wbuf_open_o, 1'b0);
    wr_cmd_end_i = 1; tick(); clear_strobes();
    buf_space_i = 1; tick(); clear_strobes();
    chk("R9 open on space", wbuf_open_o, 1'b1);
    chk("R9 ready pulse", wr_ready_irq_o, 1'b1);
    tick();
    chk("R9 ready pulse one cycle", wr_ready_irq_o, 1'b0);
    chk("R9 stays open", wbuf_open_o, 1'b1);
    buf_full_i = 1; tick(); clear_strobes();
    chk("R9 closes on full", wbuf_open_o, 1'b0);
    chk("R9 no pulse on close", wr_ready_irq_o, 1'b0);
    buf_space_i = 1; buf_full_i = 1; tick(); clear_strobes();
    chk("R10 space beats full", wbuf_open_o, 1'b1);
    dma_mode_i = 1; tick();
    chk("R9 closed in DMA mode", wbuf_open_o, 1'b0);
    buf_space_i = 1; tick(); clear_strobes();
    chk("R9 DMA space ignored", wbuf_open_o, 1'b0);
    chk("R9 DMA no pulse", wr_ready_irq_o, 1'b0);
    dma_mode_i = 0;

    // R10 command end with last-block CRC in the same cycle
    blk_evt(1'b1);
    blk_count_i = 8'd0; multi_blk_i = 0;
    wr_crc_seen_i = 1; wr_cmd_end_i = 1; tick(); clear_strobes();
    chk("R10 tx set wins", tx_busy_o, 1'b1);
    chk("R10 no done pulse", xfer_done_irq_o, 1'b0);
    blk_evt(1'b1);
    chk("R10 reloaded single block ends", tx_busy_o, 1'b0);
    chk("R4 done after reload", xfer_done_irq_o, 1'b1);

    tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule